// File: doc/BRIEF.md
# TFT Panel Power Sequencer

This block brings a TFT panel up and down in a safe order. It drives three panel controls: the supply enable, the enable for the data and control signals, and the backlight enable. Going up, the supply comes first, then the signals, then the backlight. Going down, the order is reversed. The wait between two steps comes from a configuration word. Each wait is counted in units of a prescaled 10 ms tick, which is derived from the reference clock. After a full power-down, a minimum rest time must pass before the panel may be powered again.

Software reaches the block through a small word-wide register port. The port has a configuration word that accepts only its first write, a control bit and a read-only status word. Setting the control bit to 1 asks for power-up and clearing it asks for power-down. A sequence that has started always runs to its end. The stable state it reaches is then compared with the control bit, and a new sequence starts if the two disagree. The supply and backlight outputs each have their own programmable active level. The signal enable output is always active high.

Top module: `lcd_pwr_seq`

## Requirements
- R1: The configuration word (address 0) takes the first write after reset and sets the lock flag. Every later write to address 0 leaves its read-back value and the panel outputs unchanged.
- R2: After reset the configuration word reads 0xE00B3723. This means enable bit 31 = 1, supply polarity bit 30 = 1, backlight polarity bit 29 = 1, rest code bits 19:16 = 11, signals-off-to-supply-off code bits 15:12 = 3, backlight-off-to-signals-off code bits 11:8 = 7, signals-on-to-backlight-on code bits 7:4 = 2 and supply-on-to-signals-on code bits 3:0 = 3.
- R3: One tick is TICK_CYC clock cycles. A code N in a short field (bits 3:0 and 15:12) gives a wait of N+1 ticks. A code N in a long field (bits 7:4, 11:8 and 19:16) gives a wait of (N+1)×LONG_MULT ticks.
- R4: Power-up starts from the idle state when the control bit reads 1. The supply asserts one cycle after the edge that stored the bit. The signals assert after the bits 3:0 wait, and the backlight asserts after a further bits 7:4 wait.
- R5: Power-down starts from the fully-on state when the control bit reads 0. The backlight deasserts one cycle after the edge that stored the bit. The signals deassert after the bits 11:8 wait, and the supply deasserts after a further bits 15:12 wait.
- R6: After the supply deasserts at the end of power-down, the block rests for the bits 19:16 wait. A power-up request made in the meantime is held, and the supply reasserts one cycle after the rest ends.
- R7: The supply pin is high when active if bit 30 is 1, and low when active if bit 30 is 0. The backlight pin follows bit 29 in the same way. The signal enable pin is active high.
- R8: The control bit (address 1, bit 0) reads back the last value written to it, and writing the same value again has no effect. A request in the opposite direction during a sequence lets that sequence finish and is acted on afterwards.
- R9: While the enable bit 31 is 0, all three outputs are held at their inactive levels and the control bit reads 0 whatever is written to it.
- R10: The status word (address 2) carries the state code in bits 2:0, a busy flag in bit 3 and the lock flag in bit 4. The state codes are: idle 0, supply-on wait 1, signals-on wait 2, on 3, backlight-off wait 4, signals-off wait 5, rest 6. Busy is set in every state except idle and on.
- R11: Read data is combinational from the address. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 2 | Word address: 0 config, 1 control, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| panel_supply_o | output | 1 | Panel supply enable, level set by bit 30 |
| panel_sig_en_o | output | 1 | Data/control signal enable, active high |
| panel_bklt_o | output | 1 | Backlight enable, level set by bit 29 |

## Verification
The assertions turn pin levels back into active/inactive states using the registered polarity bits. They therefore assume that a write lasts a single cycle and that its address and data are valid while reg_wr is high. They also assume that the configuration word is written at most once between resets. The bench drives every bus access at a falling edge and holds the strobe for exactly one rising edge. It predicts each pin change from the cycle of that edge, and it re-asserts reset before it starts from a new configuration.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_UP_SUP  = 3'd1,
        ST_UP_SIG  = 3'd2,
        ST_ON      = 3'd3,
        ST_DN_BKL  = 3'd4,
        ST_DN_SIG  = 3'd5,
        ST_DN_REST = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic       sup_pol;
        logic       bkl_pol;
        logic [3:0] w_rest;
        logic [3:0] w_sig_sup;
        logic [3:0] w_bkl_sig;
        logic [3:0] w_sig_bkl;
        logic [3:0] w_sup_sig;
    } panel_cfg_t;

    localparam panel_cfg_t CFG_RESET = '{
        en: 1'b1, sup_pol: 1'b1, bkl_pol: 1'b1,
        w_rest: 4'd11, w_sig_sup: 4'd3, w_bkl_sig: 4'd7,
        w_sig_bkl: 4'd2, w_sup_sig: 4'd3
    };

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CTL  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    function automatic logic [31:0] cfg_pack(input panel_cfg_t c);
        return {c.en, c.sup_pol, c.bkl_pol, 9'd0, c.w_rest, c.w_sig_sup,
                c.w_bkl_sig, c.w_sig_bkl, c.w_sup_sig};
    endfunction

endpackage

// File: rtl/lcd_pwr_tick.sv
module lcd_pwr_tick #(
    parameter int TICK_CYC = 270000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_pwr_timer.sv
module lcd_pwr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] load,
    input  logic          tick,
    output logic          done
);
    typedef struct packed {
        logic          run;
        logic [TW-1:0] rem;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.run && tick && (t_q.rem == TW'(1));

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.rem = load;
        end else if (t_q.run && tick) begin
            if (t_q.rem == TW'(1)) t_d.run = 1'b0;
            t_d.rem = t_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
#(
    parameter int TICK_CYC  = 270000,
    parameter int LONG_MULT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        panel_supply_o,
    output logic        panel_sig_en_o,
    output logic        panel_bklt_o
);
    localparam int TW = $clog2(16 * LONG_MULT + 1);

    typedef struct packed {
        panel_cfg_t cfg;
        logic       locked;
        logic       ctl;
        seq_state_e st;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    panel_cfg_t cfg_q;
    seq_state_e st_q;
    logic       locked_q, ctl_q;
    logic       tmr_start, tmr_done, tick;
    logic [TW-1:0] tmr_load;
    logic       sup_act, sig_act, bkl_act, busy;
    logic       unused_wdata;

    assign cfg_q    = r_q.cfg;
    assign st_q     = r_q.st;
    assign locked_q = r_q.locked;
    assign ctl_q    = r_q.ctl;
    assign unused_wdata = ^reg_wdata[28:20];

    function automatic logic [TW-1:0] span(input logic [3:0] code, input logic long_step);
        logic [TW-1:0] base;
        base = TW'(code) + TW'(1);
        return long_step ? TW'(base * TW'(LONG_MULT)) : base;
    endfunction

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        tmr_load  = '0;
        if (reg_wr && reg_addr == ADDR_CFG && !r_q.locked) begin
            r_d.cfg = '{en: reg_wdata[31], sup_pol: reg_wdata[30], bkl_pol: reg_wdata[29],
                        w_rest: reg_wdata[19:16], w_sig_sup: reg_wdata[15:12],
                        w_bkl_sig: reg_wdata[11:8], w_sig_bkl: reg_wdata[7:4],
                        w_sup_sig: reg_wdata[3:0]};
            r_d.locked = 1'b1;
        end
        if (reg_wr && reg_addr == ADDR_CTL) r_d.ctl = reg_wdata[0];
        if (!r_d.cfg.en) begin
            r_d.ctl = 1'b0;
            r_d.st  = ST_OFF;
        end else begin
            unique case (r_q.st)
                ST_OFF: if (r_q.ctl) begin
                    r_d.st = ST_UP_SUP; tmr_start = 1'b1;
                    tmr_load = span(r_q.cfg.w_sup_sig, 1'b0);
                end
                ST_UP_SUP: if (tmr_done) begin
                    r_d.st = ST_UP_SIG; tmr_start = 1'b1;
                    tmr_load = span(r_q.cfg.w_sig_bkl, 1'b1);
                end
                ST_UP_SIG: if (tmr_done) r_d.st = ST_ON;
                ST_ON: if (!r_q.ctl) begin
                    r_d.st = ST_DN_BKL; tmr_start = 1'b1;
                    tmr_load = span(r_q.cfg.w_bkl_sig, 1'b1);
                end
                ST_DN_BKL: if (tmr_done) begin
                    r_d.st = ST_DN_SIG; tmr_start = 1'b1;
                    tmr_load = span(r_q.cfg.w_sig_sup, 1'b0);
                end
                ST_DN_SIG: if (tmr_done) begin
                    r_d.st = ST_DN_REST; tmr_start = 1'b1;
                    tmr_load = span(r_q.cfg.w_rest, 1'b1);
                end
                ST_DN_REST: if (tmr_done) r_d.st = ST_OFF;
                default: r_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: CFG_RESET, locked: 1'b0, ctl: 1'b0, st: ST_OFF};
        else        r_q <= r_d;
    end

    lcd_pwr_tick #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tmr_start), .tick(tick)
    );

    lcd_pwr_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
        .tick(tick), .done(tmr_done)
    );

    assign sup_act = (st_q != ST_OFF) && (st_q != ST_DN_REST);
    assign sig_act = (st_q == ST_UP_SIG) || (st_q == ST_ON) || (st_q == ST_DN_BKL);
    assign bkl_act = (st_q == ST_ON);
    assign busy    = (st_q != ST_OFF) && (st_q != ST_ON);

    assign panel_supply_o = sup_act ^ ~cfg_q.sup_pol;
    assign panel_sig_en_o = sig_act;
    assign panel_bklt_o   = bkl_act ^ ~cfg_q.bkl_pol;

    always_comb begin
        case (reg_addr)
            ADDR_CFG:  reg_rdata = cfg_pack(cfg_q);
            ADDR_CTL:  reg_rdata = {31'd0, ctl_q};
            ADDR_STAT: reg_rdata = {27'd0, locked_q, busy, st_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcd_pwr_chk.sv
module lcd_pwr_chk
    import lcd_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sup_pin,
    input logic       sig_pin,
    input logic       bkl_pin,
    input panel_cfg_t cfg,
    input logic       locked,
    input logic       ctl,
    input seq_state_e st
);
    logic sup_on, sig_on, bkl_on;
    assign sup_on = sup_pin ^ ~cfg.sup_pol;
    assign sig_on = sig_pin;
    assign bkl_on = bkl_pin ^ ~cfg.bkl_pol;

    p_bklt_after_sig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bkl_on |-> sig_on);

    p_sig_within_supply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sig_on |-> sup_on);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (!sup_on && !sig_on && !bkl_on && !ctl));

    p_lock_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg)));

    p_up_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_on) |-> ($past(st) == ST_OFF));
endmodule

bind lcd_pwr_seq lcd_pwr_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .sup_pin(panel_supply_o), .sig_pin(panel_sig_en_o), .bkl_pin(panel_bklt_o),
    .cfg(cfg_q), .locked(locked_q), .ctl(ctl_q), .st(st_q)
);

// File: tb/test_lcd_pwr_seq.sv
module test_lcd_pwr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 4;
    localparam int LM   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sup, sig, bkl;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    logic [2:0] prev;

    int         q_cyc[$];
    logic [2:0] q_val[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_pwr_seq #(.TICK_CYC(TICK), .LONG_MULT(LM)) i_lcd_pwr_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .panel_supply_o(sup), .panel_sig_en_o(sig), .panel_bklt_o(bkl)
    );

    // Monitor: every pin change must match the next scoreboard entry
    always @(negedge clk) begin
        if (!rst_n) prev = {sup, sig, bkl};
        else if ({sup, sig, bkl} !== prev) begin
            nchk++;
            if (q_cyc.size() == 0) begin
                nfail++;
                $display("FAIL unexpected pin change: actual %b at cycle %0d, expected no change",
                         {sup, sig, bkl}, cyc);
            end else begin
                automatic int         ec = q_cyc.pop_front();
                automatic logic [2:0] ev = q_val.pop_front();
                automatic string      et = q_tag.pop_front();
                if (ec != cyc || ev !== {sup, sig, bkl}) begin
                    nfail++;
                    $display("FAIL %s pins: actual %b at cycle %0d, expected %b at cycle %0d",
                             et, {sup, sig, bkl}, cyc, ev, ec);
                end
            end
            prev = {sup, sig, bkl};
        end
    end

    task automatic push(input int c, input logic [2:0] v, input string t);
        q_cyc.push_back(c); q_val.push_back(v); q_tag.push_back(t);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        q_cyc.delete(); q_val.delete(); q_tag.delete();
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w;
        do_reset();

        // Reset state
        rd(2'd0, d); check(d, 32'hE00B3723, "R2 reset config");
        rd(2'd2, d); check(d, 32'h0, "R10 reset status");
        rd(2'd1, d); check(d, 32'h0, "R8 reset control");
        rd(2'd3, d); check(d, 32'h0, "R11 unmapped read");
        check({29'd0, sup, sig, bkl}, 32'h0, "R7 reset pins");

        // Config: en, supply active high, backlight active low, t6=1 t5=2 t4=0 t3=1 t2=0
        w = cyc + 1;
        push(w, 3'b001, "R7 backlight idle level");
        wr(2'd0, 32'hC001_2010);
        rd(2'd0, d); check(d, 32'hC001_2010, "R1 first write taken");
        rd(2'd2, d); check(d, 32'h10, "R10 lock flag");
        wr(2'd0, 32'hE00B_3723);
        rd(2'd0, d); check(d, 32'hC001_2010, "R1 second write ignored");

        // Power-up
        w = cyc + 1;
        push(w + 1, 3'b101, "R4 supply on");
        push(w + 5, 3'b111, "R4 signals on");
        push(w + 85, 3'b110, "R4 backlight on");
        wr(2'd1, 32'h1);
        rd(2'd1, d); check(d, 32'h1, "R8 control readback");
        idle(2);
        rd(2'd2, d); check(d, 32'h19, "R10 supply wait status");
        wr(2'd1, 32'h1);
        idle(90);
        rd(2'd2, d); check(d, 32'h13, "R10 on status");

        // Power-down, re-request mid-sequence, held through rest
        w = cyc + 1;
        push(w + 1, 3'b111, "R5 backlight off");
        push(w + 41, 3'b101, "R5 signals off");
        push(w + 53, 3'b001, "R5 supply off");
        push(w + 134, 3'b101, "R6 supply on after rest");
        push(w + 138, 3'b111, "R8 signals on after reversal");
        push(w + 218, 3'b110, "R8 backlight on after reversal");
        wr(2'd1, 32'h0);
        idle(44);
        rd(2'd2, d); check(d, 32'h1D, "R10 signals-off wait status");
        wr(2'd1, 32'h1);
        idle(14);
        rd(2'd2, d); check(d, 32'h1E, "R6 rest status");
        idle(165);
        rd(2'd2, d); check(d, 32'h13, "R8 back on");

        // Full power-down
        w = cyc + 1;
        push(w + 1, 3'b111, "R5 backlight off");
        push(w + 41, 3'b101, "R5 signals off");
        push(w + 53, 3'b001, "R5 supply off");
        wr(2'd1, 32'h0);
        idle(140);
        rd(2'd2, d); check(d, 32'h10, "R5 idle after power-down");

        // Default delays
        do_reset();
        wr(2'd0, 32'hE00B_3723);
        w = cyc + 1;
        push(w + 1, 3'b100, "R3 supply on");
        push(w + 17, 3'b110, "R3 short step code 3");
        push(w + 137, 3'b111, "R3 long step code 2");
        wr(2'd1, 32'h1);
        idle(145);
        rd(2'd2, d); check(d, 32'h13, "R3 on status");

        // Disabled interface, both polarities active low
        do_reset();
        w = cyc + 1;
        push(w, 3'b101, "R9 inactive levels");
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h1);
        rd(2'd1, d); check(d, 32'h0, "R9 control held at 0");
        idle(200);
        rd(2'd2, d); check(d, 32'h10, "R9 stays idle");
        check({29'd0, sup, sig, bkl}, 32'h5, "R9 pins inactive");

        check(q_cyc.size(), 0, "R4 all expected pin changes seen");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule